// File: doc/BRIEF.md
# FP8 to FP32 Decoder

This block widens one 8-bit floating-point code into the bit pattern of an IEEE-754 single-precision number. A one-bit format select picks the layout of the incoming byte. The first layout has four exponent bits and three fraction bits. The second has five exponent bits and two fraction bits. Every FP8 value fits exactly in single precision, so the conversion is a re-encoding and never rounds.

Weights in inference datapaths are stored in these compact formats and decoded just before use. For that reason the block never passes on a special code. Every NaN or infinity code becomes positive zero, so a corrupt weight contributes nothing to an accumulated sum.

Subnormal codes are normalised: a leading-one search on the fraction sets the single-precision exponent. A code with a zero exponent and a zero fraction becomes a zero that keeps its sign.

The decode logic is combinational. By default an output register stage follows it and adds one cycle of latency. A parameter removes that stage.

Top module: `fp8_to_fp32_decoder`

## Requirements
- R1: With `fmt_sel`=0 (the 4-bit-exponent format), bit 7 is the sign, bits 6:3 the exponent (bias 7) and bits 2:0 the fraction. A code with a nonzero exponent decodes to sign, exponent e+120 and fraction bits placed at output bits 22:20.
- R2: With `fmt_sel`=0, a code with exponent 0 and nonzero fraction m has value m·2^-9. It is emitted normalised, with exponent 118+p, where p is the position of the leading one of m, and the fraction bits below that one are placed from bit 22 downward.
- R3: With `fmt_sel`=0, the codes 0x7F and 0xFF both yield 0x00000000.
- R4: With `fmt_sel`=1 (the 5-bit-exponent format), bit 7 is the sign, bits 6:2 the exponent (bias 15) and bits 1:0 the fraction. A code with an exponent of 1 to 30 decodes to exponent e+112 and fraction bits placed at output bits 22:21.
- R5: With `fmt_sel`=1, a code with exponent 0 and nonzero fraction m has value m·2^-16 and is emitted normalised (0x01 gives 0x37800000).
- R6: With `fmt_sel`=1, every code whose exponent field is 31 yields 0x00000000, whatever its sign and fraction.
- R7: In both formats, a code with a zero exponent and a zero fraction yields a zero with the input sign: 0x00 gives 0x00000000 and 0x80 gives 0x80000000.
- R8: `fmt_sel` is applied per code. The same byte decodes by the selected format, so 0x38 gives 0x3F800000 with `fmt_sel`=0, and 0x3C gives 0x3F800000 with `fmt_sel`=1.
- R9: With the default registered output, `out_valid` equals `in_valid` from one clock earlier, and `out_bits` carries the result for that code in the same cycle.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_bits` to zero at the next clock edge.
- R11: With the registered output, a cycle with `in_valid` low leaves `out_bits` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_code` as a code to convert |
| in_code | input | 8 | FP8 code |
| fmt_sel | input | 1 | 0: 4-bit-exponent format, 1: 5-bit-exponent format |
| out_valid | output | 1 | Marks `out_bits` as a converted result |
| out_bits | output | 32 | Single-precision bit pattern |

## Verification
The bench sweeps all 256 codes in both formats. It compares each result with a decoder that works on real numbers and then re-encodes the value through repeated halving and doubling.

That sweep exposes several faults:
- A normaliser with an off-by-one leading-one position shows up on every subnormal, as a doubled or halved value.
- A special-code test that checks only one sign, or only the all-ones fraction, lets 0xFF, or the E5M2 infinities, leak through as non-zero patterns.
- Clearing the sign on zeros turns 0x80 into +0.

Directed cases check the following:
- The format select is honoured: one byte is decoded under both formats.
- Valid tracking and output hold work: an idle cycle must keep the last result rather than load the idle code.
- The reset clears the output register.

// File: rtl/fp8dec_pkg.sv
package fp8dec_pkg;

  localparam int CODE_W   = 8;
  localparam int F32_W    = 32;
  localparam int F32_EW   = 8;
  localparam int F32_MW   = 23;
  localparam int F32_BIAS = 127;
  localparam int ALIGN_MW = 3;               // widest FP8 fraction
  localparam int LEAD_W   = $clog2(ALIGN_MW);
  localparam int EXP_MAXW = 5;               // widest FP8 exponent

  typedef enum logic {
    FMT_E4M3 = 1'b0,
    FMT_E5M2 = 1'b1
  } fp8_fmt_e;

  typedef struct packed {
    logic                sign;
    logic [EXP_MAXW-1:0] expo;
    logic [ALIGN_MW-1:0] frac;      // left aligned
    logic [F32_EW-1:0]   rebias;    // F32_BIAS - format bias
    logic                special;
    logic                exp_zero;
    logic                frac_zero;
  } fp8_fields_t;

  // Position of the highest set bit of a left-aligned fraction.
  function automatic logic [LEAD_W-1:0] lead_one(input logic [ALIGN_MW-1:0] f);
    logic [LEAD_W-1:0] pos;
    pos = '0;
    for (int i = 0; i < ALIGN_MW; i++) begin
      if (f[i]) pos = LEAD_W'(i);
    end
    return pos;
  endfunction

  // Bits below the leading one, moved to the top of the fraction field.
  function automatic logic [ALIGN_MW-1:0] below_lead(input logic [ALIGN_MW-1:0] f,
                                                     input logic [LEAD_W-1:0]   p);
    logic [2*ALIGN_MW-1:0] wide;
    wide = {{ALIGN_MW{1'b0}}, f} << (ALIGN_MW - int'(p));
    return wide[ALIGN_MW-1:0];
  endfunction

endpackage

// File: rtl/fp8_field_split.sv
module fp8_field_split
  import fp8dec_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  fp8_fmt_e          fmt,
  output fp8_fields_t       fields
);

  localparam int E4_BIAS = 7;
  localparam int E5_BIAS = 15;

  always_comb begin
    fields.sign = code[CODE_W-1];
    if (fmt == FMT_E4M3) begin
      fields.expo    = {1'b0, code[6:3]};
      fields.frac    = code[2:0];
      fields.rebias  = F32_EW'(F32_BIAS - E4_BIAS);
      fields.special = (code[6:0] == 7'h7F);
    end else begin
      fields.expo    = code[6:2];
      fields.frac    = {code[1:0], 1'b0};
      fields.rebias  = F32_EW'(F32_BIAS - E5_BIAS);
      fields.special = (code[6:2] == 5'h1F);
    end
    fields.exp_zero  = (fields.expo == '0);
    fields.frac_zero = (fields.frac == '0);
  end

endmodule

// File: rtl/fp8_subnorm_norm.sv
module fp8_subnorm_norm
  import fp8dec_pkg::*;
(
  input  logic [ALIGN_MW-1:0] frac,
  input  logic [F32_EW-1:0]   rebias,
  output logic [F32_EW-1:0]   sub_exp,
  output logic [ALIGN_MW-1:0] sub_frac
);

  logic [LEAD_W-1:0] lead_pos;

  always_comb begin
    lead_pos = lead_one(frac);
    // value = frac/2^ALIGN_MW * 2^(1-bias); exponent = 1-bias+p-ALIGN_MW
    sub_exp  = rebias + F32_EW'(1) + F32_EW'(lead_pos) - F32_EW'(ALIGN_MW);
    sub_frac = below_lead(frac, lead_pos);
  end

endmodule

// File: rtl/fp8_pack_fp32.sv
module fp8_pack_fp32
  import fp8dec_pkg::*;
(
  input  fp8_fields_t         fields,
  input  logic [F32_EW-1:0]   sub_exp,
  input  logic [ALIGN_MW-1:0] sub_frac,
  output logic [F32_W-1:0]    result
);

  localparam int PAD_W = F32_MW - ALIGN_MW;

  always_comb begin
    if (fields.special) begin
      result = '0;
    end else if (fields.exp_zero && fields.frac_zero) begin
      result = {fields.sign, {(F32_W-1){1'b0}}};
    end else if (fields.exp_zero) begin
      result = {fields.sign, sub_exp, sub_frac, {PAD_W{1'b0}}};
    end else begin
      result = {fields.sign,
                F32_EW'(fields.expo) + fields.rebias,
                fields.frac, {PAD_W{1'b0}}};
    end
  end

endmodule

// File: rtl/fp8_to_fp32_decoder.sv
module fp8_to_fp32_decoder
  import fp8dec_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic              fmt_sel,
  output logic              out_valid,
  output logic [F32_W-1:0]  out_bits
);

  fp8_fields_t         fields;
  logic [F32_EW-1:0]   sub_exp;
  logic [ALIGN_MW-1:0] sub_frac;
  logic [F32_W-1:0]    result_comb;

  // named events for the checker
  logic code_special;
  logic code_subnorm;
  logic code_zero;

  fp8_field_split u_split (
    .code   (in_code),
    .fmt    (fp8_fmt_e'(fmt_sel)),
    .fields (fields)
  );

  fp8_subnorm_norm u_norm (
    .frac     (fields.frac),
    .rebias   (fields.rebias),
    .sub_exp  (sub_exp),
    .sub_frac (sub_frac)
  );

  fp8_pack_fp32 u_pack (
    .fields   (fields),
    .sub_exp  (sub_exp),
    .sub_frac (sub_frac),
    .result   (result_comb)
  );

  assign code_special = fields.special;
  assign code_subnorm = fields.exp_zero && !fields.frac_zero;
  assign code_zero    = fields.exp_zero && fields.frac_zero;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          out_bits  <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) out_bits <= result_comb;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign out_bits  = result_comb;
    end
  endgenerate

endmodule

// File: rtl/fp8_decode_checker.sv
module fp8_decode_checker #(
  parameter bit OUT_REG = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [7:0]  in_code,
  input logic        fmt_sel,
  input logic        out_valid,
  input logic [31:0] out_bits,
  input logic        code_special,
  input logic        code_subnorm,
  input logic        code_zero
);

  generate
    if (OUT_REG) begin : g_reg_chk
      // R3
      special_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_special && !fmt_sel) |=> (out_bits == 32'h0));
      // R6
      e5_special_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_special && fmt_sel) |=> (out_bits == 32'h0));
      // R7
      signed_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_zero) |=> (out_bits == {$past(in_code[7]), 31'h0}));
      // R2
      subnorm_exp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_subnorm) |=>
          (out_bits[30:23] != 8'h0 && out_bits[30:23] < 8'd121 &&
           out_bits[31] == $past(in_code[7])));
      // R9
      valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
      // R9
      valid_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
      // R10
      reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_bits == 32'h0));
      // R11
      hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_bits));
    end else begin : g_comb_chk
      // R3
      special_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_special) |-> (out_bits == 32'h0));
      // R7
      signed_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_zero) |-> (out_bits == {in_code[7], 31'h0}));
      // R2
      subnorm_exp_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && code_subnorm) |-> (out_bits[30:23] != 8'h0));
      // R9
      valid_pass_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == in_valid);
    end
  endgenerate

endmodule

bind fp8_to_fp32_decoder fp8_decode_checker #(.OUT_REG(OUT_REG)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_code      (in_code),
  .fmt_sel      (fmt_sel),
  .out_valid    (out_valid),
  .out_bits     (out_bits),
  .code_special (code_special),
  .code_subnorm (code_subnorm),
  .code_zero    (code_zero)
);

// File: tb/fp8_to_fp32_decoder_test.sv
module fp8_to_fp32_decoder_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [7:0]  in_code;
  logic        fmt_sel;
  logic        out_valid;
  logic [31:0] out_bits;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  fp8_to_fp32_decoder uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .fmt_sel   (fmt_sel),
    .out_valid (out_valid),
    .out_bits  (out_bits)
  );

  // Reference: real value, then re-encode by halving / doubling.
  function automatic logic [31:0] ref_bits(input logic [7:0] c, input logic f);
    int    e, m, mb, bias;
    real   mag, a;
    int    k;
    logic  s;
    logic [31:0] r;
    s = c[7];
    if (!f) begin e = int'(c[6:3]); m = int'(c[2:0]); mb = 3; bias = 7; end
    else    begin e = int'(c[6:2]); m = int'(c[1:0]); mb = 2; bias = 15; end
    if (!f && c[6:0] == 7'h7F) return 32'h0;
    if (f && e == 31) return 32'h0;
    if (e == 0) mag = (real'(m) / real'(1 << mb)) * (2.0 ** (1 - bias));
    else        mag = (1.0 + real'(m) / real'(1 << mb)) * (2.0 ** (e - bias));
    if (mag == 0.0) return {s, 31'h0};
    a = mag; k = 0;
    while (a >= 2.0) begin a = a / 2.0; k++; end
    while (a < 1.0)  begin a = a * 2.0; k--; end
    r[31]    = s;
    r[30:23] = 8'(k + 127);
    r[22:0]  = 23'(longint'((a - 1.0) * 8388608.0));
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [7:0] c, input logic f, input logic v);
    @(negedge clk);
    in_code = c; fmt_sel = f; in_valid = v;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; in_code = 8'h0; fmt_sel = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset out_valid", {31'h0, out_valid}, 32'h0);
    check("R10 reset out_bits", out_bits, 32'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_sweep(input logic f);
    for (int c = 0; c < 256; c++) begin
      apply(8'(c), f, 1'b1);
      if (!f) check("R1/R2/R3 E4M3 sweep", out_bits, ref_bits(8'(c), f));
      else    check("R4/R5/R6 E5M2 sweep", out_bits, ref_bits(8'(c), f));
    end
  endtask

  task automatic t_points();
    apply(8'h38, 1'b0, 1'b1); check("R1 R8 E4M3 one", out_bits, 32'h3F800000);
    apply(8'h7E, 1'b0, 1'b1); check("R1 E4M3 max 448", out_bits, 32'h43E00000);
    apply(8'h01, 1'b0, 1'b1); check("R2 E4M3 min sub", out_bits, 32'h3B000000);
    apply(8'h03, 1'b0, 1'b1); check("R2 E4M3 sub 3", out_bits, 32'h3BC00000);
    apply(8'h7F, 1'b0, 1'b1); check("R3 E4M3 0x7F", out_bits, 32'h0);
    apply(8'hFF, 1'b0, 1'b1); check("R3 E4M3 0xFF", out_bits, 32'h0);
    apply(8'h3C, 1'b1, 1'b1); check("R4 R8 E5M2 one", out_bits, 32'h3F800000);
    apply(8'h7B, 1'b1, 1'b1); check("R4 E5M2 max", out_bits, 32'h47600000);
    apply(8'h01, 1'b1, 1'b1); check("R5 E5M2 min sub", out_bits, 32'h37800000);
    apply(8'hFC, 1'b1, 1'b1); check("R6 E5M2 -inf", out_bits, 32'h0);
    apply(8'h7D, 1'b1, 1'b1); check("R6 E5M2 nan", out_bits, 32'h0);
    apply(8'h80, 1'b0, 1'b1); check("R7 E4M3 -0", out_bits, 32'h80000000);
    apply(8'h80, 1'b1, 1'b1); check("R7 E5M2 -0", out_bits, 32'h80000000);
    apply(8'h00, 1'b1, 1'b1); check("R7 E5M2 +0", out_bits, 32'h0);
    apply(8'h38, 1'b1, 1'b1); check("R8 0x38 as E5M2", out_bits, 32'h3F000000);
  endtask

  task automatic t_valid_hold();
    apply(8'h40, 1'b0, 1'b1);
    check("R9 valid follows", {31'h0, out_valid}, 32'h1);
    check("R9 data with valid", out_bits, 32'h40000000);
    apply(8'h7E, 1'b0, 1'b0);
    check("R9 valid drops", {31'h0, out_valid}, 32'h0);
    check("R11 hold on idle", out_bits, 32'h40000000);
    apply(8'h01, 1'b1, 1'b0);
    check("R11 hold second idle", out_bits, 32'h40000000);
    apply(8'hC0, 1'b0, 1'b1);
    check("R9 valid again", {31'h0, out_valid}, 32'h1);
    check("R1 negative two", out_bits, 32'hC0000000);
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    check("R10 mid reset valid", {31'h0, out_valid}, 32'h0);
    check("R10 mid reset bits", out_bits, 32'h0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    t_reset();
    t_points();
    t_sweep(1'b0);
    t_sweep(1'b1);
    t_valid_hold();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule